// File: doc/BRIEF.md
# Double-Buffered Time-Slot Interchanger

The block switches bytes between time slots of a single serial stream whose frame holds 128 slots. One slot enters per clock cycle. A frame-sync input marks slot 0, and a free-running slot counter numbers the slots that follow. Every incoming byte is written into one of two data buffers. The two buffers swap roles at each frame sync, so one buffer always holds the frame now arriving and the other holds the frame before it.

A connection table has one entry for each output slot. An entry names a source slot, carries an enable bit, and carries a buffer-select bit. With the select bit clear, the connection asks for minimum delay: the output slot reads the buffer being filled in this frame. This is possible only when the source slot came earlier than the output slot. When it did not, the block falls back to the previous frame's buffer. With the select bit set, the connection always reads the previous frame's buffer, which gives a fixed latency of one frame plus the slot delta. A block of connections that must stay together across a frame boundary uses this setting.

A two-bit control register can replace every per-connection select bit with one global value. Software writes both the table and the control register through one simple write port.

Top module: `tsi_core`

## Requirements
- R1: While reset is held, and in the cycle after it, `slot_dout_o` is 0xFF. After reset every table entry is disabled and the control register is 0.
- R2: An input byte presented with `fsync_i` high is slot 0. Each following cycle without `fsync_i` is the next slot number, and the count wraps from 127 to 0. A frame sync arriving after an idle stretch of any length realigns the numbering.
- R3: If the table entry of output slot t has its enable bit (write-data bit 8) clear, then `slot_dout_o` is 0xFF one cycle after input slot t.
- R4: An enabled entry with select bit (write-data bit 7) clear, no override active, and source s < t drives out input slot s of the same frame. The byte appears on `slot_dout_o` one cycle after input slot t.
- R5: An enabled entry with select bit set and no override active drives out input slot s of the previous frame. Its latency is 128 + (t − s) slots.
- R6: With minimum delay chosen and s ≥ t (a reverse connection, or a delta of 0), the output falls back to input slot s of the previous frame.
- R7: When control bit 1 is set, every per-connection select bit is ignored and control bit 0 is used in its place. A value of 1 means previous frame for all connections. A value of 0 means minimum delay, with the reverse fallback of R6 still applied.
- R8: When control bit 1 is clear, control bit 0 has no effect on any output.
- R9: A write with `cfg_ctrl_i` low stores `{enable, select, source[6:0]}` from `cfg_wdata_i[8:0]` into the entry for output slot `cfg_addr_i`. A later write to the same address replaces it.
- R10: The extreme deltas work. Source 0 to output 127 with minimum delay gives the same frame. Source 127 to output 0 gives the previous frame.
- R11: A write with `cfg_ctrl_i` high loads the control register from `cfg_wdata_i[1:0]`. Bit 1 is the override and bit 0 is the global select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one time slot per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| fsync_i | input | 1 | High with the byte of slot 0 |
| slot_din_i | input | 8 | Incoming slot byte |
| slot_dout_o | output | 8 | Switched byte for the slot presented one cycle earlier |
| cfg_we_i | input | 1 | Write strobe of the configuration port |
| cfg_ctrl_i | input | 1 | 1 selects the control register, 0 selects the connection table |
| cfg_addr_i | input | 7 | Output slot whose table entry is written |
| cfg_wdata_i | input | 9 | Entry `{enable, select, source}` or control `{override, global}` in bits 1:0 |

## Verification
The bench builds the block with its default parameters: a 128-slot frame and byte-wide slots. These values put the signed deltas of ±37 and the extreme ±127 within reach, along with a delta of 0. Each input byte carries its slot number in bits 6:0 and the parity of its frame in bit 7. From this the scoreboard can tell whether an output came from the current or the previous buffer. The same connection set is run under each of the four control-register values. The bench also rewrites a table entry, and it restarts after an idle stretch that is not a whole number of frames.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
    localparam int SLOTS_DEF  = 128;
    localparam int DATA_W_DEF = 8;
    localparam int SLOT_W     = $clog2(SLOTS_DEF);

    // One connection-table entry: enable, buffer select, source slot.
    typedef struct packed {
        logic              en;
        logic              bsel;
        logic [SLOT_W-1:0] src;
    } conn_t;

    localparam int CONN_W = $bits(conn_t);
endpackage

// File: rtl/tsi_slot_timer.sv
module tsi_slot_timer
    import tsi_pkg::*;
#(
    parameter int SLOTS = SLOTS_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fsync_i,
    output logic [SLOT_W-1:0] cur_slot_o,
    output logic              cur_wbuf_o,
    output logic              wbuf_q_o
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic              wbuf;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fsync_i) begin
            st_d.slot = '0;
            st_d.wbuf = ~st_q.wbuf;
        end else if (st_q.slot == LAST) begin
            st_d.slot = '0;
        end else begin
            st_d.slot = st_q.slot + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.slot <= LAST;
            st_q.wbuf <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    // The slot being received now, and the buffer it is written into.
    assign cur_slot_o = st_d.slot;
    assign cur_wbuf_o = st_d.wbuf;
    assign wbuf_q_o   = st_q.wbuf;
endmodule

// File: rtl/tsi_pingpong_buf.sv
module tsi_pingpong_buf
    import tsi_pkg::*;
#(
    parameter int SLOTS  = SLOTS_DEF,
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic              clk,
    input  logic              wr_buf_i,
    input  logic [SLOT_W-1:0] wr_slot_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_buf_i,
    input  logic [SLOT_W-1:0] rd_slot_i,
    output logic [DATA_W-1:0] rd_data_o
);
    localparam int DEPTH = 2 * SLOTS;

    logic [DATA_W-1:0] mem_q [DEPTH];

    // The storage array is written every cycle and has no reset.
    always_ff @(posedge clk) begin
        mem_q[{wr_buf_i, wr_slot_i}] <= wr_data_i;
    end

    assign rd_data_o = mem_q[{rd_buf_i, rd_slot_i}];
endmodule

// File: rtl/tsi_conn_table.sv
module tsi_conn_table
    import tsi_pkg::*;
#(
    parameter int SLOTS = SLOTS_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic              ctrl_sel_i,
    input  logic [SLOT_W-1:0] addr_i,
    input  logic [CONN_W-1:0] wdata_i,
    input  logic [SLOT_W-1:0] rd_slot_i,
    output conn_t             rd_entry_o,
    output logic              ovr_o,
    output logic              glob_o
);
    typedef struct packed {
        conn_t [SLOTS-1:0] tbl;
        logic              ovr;
        logic              glob;
    } tab_t;

    tab_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_i) begin
            if (ctrl_sel_i) begin
                st_d.ovr  = wdata_i[1];
                st_d.glob = wdata_i[0];
            end else begin
                st_d.tbl[addr_i] = conn_t'(wdata_i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_entry_o = st_q.tbl[rd_slot_i];
    assign ovr_o      = st_q.ovr;
    assign glob_o     = st_q.glob;
endmodule

// File: rtl/tsi_core.sv
module tsi_core
    import tsi_pkg::*;
#(
    parameter int SLOTS  = SLOTS_DEF,
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fsync_i,
    input  logic [DATA_W-1:0] slot_din_i,
    output logic [DATA_W-1:0] slot_dout_o,
    input  logic              cfg_we_i,
    input  logic              cfg_ctrl_i,
    input  logic [SLOT_W-1:0] cfg_addr_i,
    input  logic [CONN_W-1:0] cfg_wdata_i
);
    logic [SLOT_W-1:0] cur_slot;
    logic              cur_wbuf;
    logic              wbuf_q;
    conn_t             conn;
    logic              ovr, glob;
    logic              eff_bsel, use_prev, rd_buf;
    logic [DATA_W-1:0] rd_data;

    typedef struct packed {
        logic [DATA_W-1:0] dout;
    } out_t;

    out_t st_d, st_q;

    tsi_slot_timer #(.SLOTS(SLOTS)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .fsync_i    (fsync_i),
        .cur_slot_o (cur_slot),
        .cur_wbuf_o (cur_wbuf),
        .wbuf_q_o   (wbuf_q)
    );

    tsi_conn_table #(.SLOTS(SLOTS)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (cfg_we_i),
        .ctrl_sel_i (cfg_ctrl_i),
        .addr_i     (cfg_addr_i),
        .wdata_i    (cfg_wdata_i),
        .rd_slot_i  (cur_slot),
        .rd_entry_o (conn),
        .ovr_o      (ovr),
        .glob_o     (glob)
    );

    tsi_pingpong_buf #(.SLOTS(SLOTS), .DATA_W(DATA_W)) u_buf (
        .clk       (clk),
        .wr_buf_i  (cur_wbuf),
        .wr_slot_i (cur_slot),
        .wr_data_i (slot_din_i),
        .rd_buf_i  (rd_buf),
        .rd_slot_i (conn.src),
        .rd_data_o (rd_data)
    );

    always_comb begin
        // The global setting replaces the per-connection bit under override.
        eff_bsel = ovr ? glob : conn.bsel;
        // Only a source that arrived earlier in this frame can be read now.
        use_prev = eff_bsel || (conn.src >= cur_slot);
        rd_buf   = use_prev ? ~cur_wbuf : cur_wbuf;
        st_d.dout = conn.en ? rd_data : '1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.dout <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign slot_dout_o = st_q.dout;
endmodule

// File: rtl/tsi_core_chk.sv
module tsi_core_chk
    import tsi_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fsync_i,
    input logic [SLOT_W-1:0] cur_slot,
    input logic              cur_wbuf,
    input logic              wbuf_q,
    input logic              rd_buf,
    input logic              conn_en,
    input logic [SLOT_W-1:0] conn_src,
    input logic              ovr,
    input logic              glob,
    input logic [DATA_W-1:0] slot_dout_o
);
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> slot_dout_o == '1);

    // R2
    sync_slot_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fsync_i |-> cur_slot == '0);

    // R2
    buf_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fsync_i |=> wbuf_q != $past(wbuf_q));

    // R2
    buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fsync_i |=> wbuf_q == $past(wbuf_q));

    // R3
    idle_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !conn_en |=> slot_dout_o == '1);

    // R6
    reverse_prev_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conn_src >= cur_slot |-> rd_buf != cur_wbuf);

    // R7
    global_prev_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && glob) |-> rd_buf != cur_wbuf);

    // R7
    global_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !glob && conn_src < cur_slot) |-> rd_buf == cur_wbuf);
endmodule

bind tsi_core tsi_core_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fsync_i     (fsync_i),
    .cur_slot    (cur_slot),
    .cur_wbuf    (cur_wbuf),
    .wbuf_q      (wbuf_q),
    .rd_buf      (rd_buf),
    .conn_en     (conn.en),
    .conn_src    (conn.src),
    .ovr         (ovr),
    .glob        (glob),
    .slot_dout_o (slot_dout_o)
);

// File: tb/tsi_core_test.sv
`timescale 1ns/1ps
module tsi_core_test;
    import tsi_pkg::*;

    localparam int SLOTS  = SLOTS_DEF;
    localparam int DATA_W = DATA_W_DEF;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              fsync_i = 1'b0;
    logic [DATA_W-1:0] slot_din_i = '0;
    logic [DATA_W-1:0] slot_dout_o;
    logic              cfg_we_i = 1'b0;
    logic              cfg_ctrl_i = 1'b0;
    logic [SLOT_W-1:0] cfg_addr_i = '0;
    logic [CONN_W-1:0] cfg_wdata_i = '0;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    // Bench record of what was written (the expected configuration).
    logic            m_en   [SLOTS];
    logic            m_bsel [SLOTS];
    int              m_src  [SLOTS];
    logic            m_ovr  = 1'b0;
    logic            m_glob = 1'b0;

    // Scoreboard queues.
    bit              q_chk [$];
    logic [7:0]      q_exp [$];
    string           q_req [$];
    int              q_slot[$];

    always #2 clk = ~clk;

    tsi_core uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .fsync_i     (fsync_i),
        .slot_din_i  (slot_din_i),
        .slot_dout_o (slot_dout_o),
        .cfg_we_i    (cfg_we_i),
        .cfg_ctrl_i  (cfg_ctrl_i),
        .cfg_addr_i  (cfg_addr_i),
        .cfg_wdata_i (cfg_wdata_i)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp, input int slot);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s slot %0d: actual=%02h expected=%02h", req, slot, act, exp);
        end
    endtask

    task automatic write_conn(input int t, input logic en, input logic bsel, input int src);
        @(negedge clk);
        cfg_we_i    = 1'b1;
        cfg_ctrl_i  = 1'b0;
        cfg_addr_i  = SLOT_W'(t);
        cfg_wdata_i = {en, bsel, SLOT_W'(src)};
        m_en[t] = en; m_bsel[t] = bsel; m_src[t] = src;
        @(negedge clk);
        cfg_we_i = 1'b0;
    endtask

    task automatic write_ctrl(input logic o, input logic g);
        @(negedge clk);
        cfg_we_i    = 1'b1;
        cfg_ctrl_i  = 1'b1;
        cfg_wdata_i = {{(CONN_W-2){1'b0}}, o, g};
        m_ovr = o; m_glob = g;
        @(negedge clk);
        cfg_we_i = 1'b0;
        cfg_ctrl_i = 1'b0;
    endtask

    // Driver: streams frames; byte = {frame parity, slot}; pushes expected outputs.
    task automatic run_frames(input int n, input string tag);
        for (int f = 0; f < n; f++) begin
            for (int s = 0; s < SLOTS; s++) begin
                logic       prev;
                logic       eff;
                int         delta;
                string      req;
                @(negedge clk);
                fsync_i    = (s == 0);
                slot_din_i = {f[0], SLOT_W'(s)};
                eff   = m_ovr ? m_glob : m_bsel[s];
                prev  = eff || (m_src[s] >= s);
                delta = s - m_src[s];
                if (!m_en[s])                 req = "R3";
                else if (m_ovr)               req = "R7";
                else if (delta == 127 || delta == -127) req = "R10";
                else if (m_bsel[s])           req = "R5";
                else if (prev)                req = "R6";
                else                          req = "R4";
                if (tag != "") req = {tag, "/", req};
                q_slot.push_back(s);
                q_req.push_back(req);
                if (!m_en[s]) begin
                    q_chk.push_back(1'b1);
                    q_exp.push_back(8'hFF);
                end else begin
                    q_chk.push_back(!(prev && f == 0));
                    q_exp.push_back({prev ? ~f[0] : f[0], SLOT_W'(m_src[s])});
                end
            end
        end
        @(negedge clk);
        fsync_i = 1'b0;
        slot_din_i = '0;
        repeat (3) @(negedge clk);
    endtask

    // Monitor: output for a slot is registered at the edge after its input.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q_chk.size() > 0) begin
                bit         c;
                logic [7:0] e;
                string      r;
                int         sl;
                c = q_chk.pop_front();
                e = q_exp.pop_front();
                r = q_req.pop_front();
                sl = q_slot.pop_front();
                if (c) check(r, slot_dout_o, e, sl);
            end
        end
    end

    task automatic standard_set();
        write_conn(38, 1'b1, 1'b0, 1);    // +37 minimum delay
        write_conn(1,  1'b1, 1'b0, 38);   // -37 reverse fallback
        write_conn(127,1'b1, 1'b0, 0);    // +127
        write_conn(0,  1'b1, 1'b0, 127);  // -127
        write_conn(50, 1'b1, 1'b1, 10);   // +40 constant delay
        write_conn(90, 1'b1, 1'b1, 127);  // -37 constant delay
        write_conn(60, 1'b1, 1'b0, 60);   // delta 0
        write_conn(100,1'b0, 1'b1, 63);   // disabled
    endtask

    initial begin
        for (int i = 0; i < SLOTS; i++) begin
            m_en[i] = 1'b0; m_bsel[i] = 1'b0; m_src[i] = 0;
        end
        repeat (4) @(negedge clk);
        check("R1", slot_dout_o, 8'hFF, -1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", slot_dout_o, 8'hFF, -1);
        // R1 / R3: every entry disabled after reset.
        run_frames(1, "R1");

        standard_set();
        write_ctrl(1'b0, 1'b0);
        run_frames(3, "");

        // R8: global bit alone changes nothing.
        write_ctrl(1'b0, 1'b1);
        run_frames(3, "R8");

        // R7 and R11: override to previous frame, then to minimum delay.
        write_ctrl(1'b1, 1'b1);
        run_frames(3, "R11");
        write_ctrl(1'b1, 1'b0);
        run_frames(3, "R11");

        // R9: rewrite entries.
        write_ctrl(1'b0, 1'b0);
        write_conn(38, 1'b0, 1'b0, 1);
        write_conn(100, 1'b1, 1'b0, 63);
        write_conn(50, 1'b1, 1'b0, 10);
        run_frames(2, "R9");

        // R2: idle stretch not a multiple of the frame, then realign.
        repeat (57) @(negedge clk);
        run_frames(3, "R2");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule